// File: doc/BRIEF.md
# One-Hot Symbol Serial Link (Transmit and Receive Ends)

This block carries data words across a point-to-point, one-way link made of four forward data wires and one backward acknowledge wire. A word enters the transmit end on a valid/ready interface. That end then sends the word as a series of 2-bit symbols. Each symbol raises exactly one of the four wires, and the wire's index is the symbol value. The receive end finds each symbol from the wire levels alone and raises the acknowledge. The sender then returns every wire to low, forming a spacer. The receiver then drops the acknowledge. Because each step waits for the other side, wire delay does not matter.

The receive end shifts the symbols back into a word. It offers the word on its own valid/ready interface once the spacer after the last symbol has been seen. Each end passes the incoming link wires through a two-stage synchroniser before using them. The top module holds one transmit end and one receive end, so two chips that each instantiate it form a full link. A single instance can also be looped back on itself.

Top module: `quad_rail_link`

## Requirements
- R1: After reset, `tx_rail` is 4'b0000, `rx_ack` is 0, `s_ready` is 1, `m_valid` is 0 and `rx_error` is 0.
- R2: `tx_rail` is always either all zero or has exactly one bit high. The 2-bit symbol value v is sent by raising bit v (value 0 on bit 0, value 3 on bit 3).
- R3: A WORD_W-bit word is sent as WORD_W/2 symbols. The first symbol is data bits [1:0], the next is bits [3:2], and so on up to the top pair.
- R4: The transmitter holds a symbol on `tx_rail` unchanged until it sees `tx_ack_in` high. It then drives all zero and keeps all zero until it sees `tx_ack_in` low, before raising the next symbol.
- R5: `s_ready` goes low in the cycle after a word is accepted. It stays low until the acknowledge for the last symbol has been seen low.
- R6: The receiver raises `rx_ack` after `rx_rail_in` shows exactly one high bit. It keeps `rx_ack` high until `rx_rail_in` returns to all zero, then drops it.
- R7: `m_valid` rises only after the spacer that follows the last symbol of a word, in the same cycle that `rx_ack` falls. `m_data` is the word rebuilt with the first symbol received in bits [1:0].
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` stay unchanged, and a new symbol on `rx_rail_in` is not acknowledged.
- R9: When more than one bit of `rx_rail_in` is high, `rx_error` goes high, no acknowledge is given, and the pattern does not count as a symbol. `rx_error` returns low once the wires return to all zero.
- R10: With the transmit wires looped to the receive wires and the acknowledge looped back, every accepted word comes out of `m_data` unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Word offered to the transmit end |
| s_ready | output | 1 | Transmit end can accept a word |
| s_data | input | WORD_W | Word to send |
| tx_rail | output | 4 | Outgoing one-hot symbol wires |
| tx_ack_in | input | 1 | Acknowledge from the far receiver |
| rx_rail_in | input | 4 | Incoming one-hot symbol wires |
| rx_ack | output | 1 | Acknowledge to the far sender |
| m_valid | output | 1 | Rebuilt word is available |
| m_ready | input | 1 | Consumer takes the word |
| m_data | output | WORD_W | Rebuilt word |
| rx_error | output | 1 | More than one incoming wire is high |

## Verification
The bench builds the block with its default values: a 32-bit word, which makes 16 symbols per word, and two synchroniser stages. With these values the symbol counter runs through its full range and wraps from 15 back to 0 on every word. The full-width data patterns (all zeros, all ones, alternating bits and random words) then reach both the first and the last symbol positions. The two synchroniser stages add enough delay that holding the acknowledge or the wires steady for several cycles shows that neither end moves ahead without the other.

// File: rtl/quad_link_pkg.sv
package quad_link_pkg;

    typedef logic [3:0] rail_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_MARK  = 2'd1,
        TX_SPACE = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_MARK  = 2'd0,
        RX_SPACE = 2'd1,
        RX_HOLD  = 2'd2
    } rx_state_e;

    // Classification of the four wire levels seen by a receiver.
    typedef struct packed {
        logic       symbol;   // exactly one wire high
        logic       clash;    // two or more wires high
        logic       spacer;   // all wires low
        logic [1:0] pair;     // decoded symbol value
    } rail_view_t;

    function automatic rail_t pair_to_rail(input logic [1:0] p);
        return rail_t'(4'b0001 << p);
    endfunction

    function automatic logic [1:0] rail_to_pair(input rail_t r);
        logic [1:0] v;
        v = 2'd0;
        for (int i = 0; i < 4; i++) begin
            if (r[i]) v = 2'(i);
        end
        return v;
    endfunction

    function automatic rail_view_t classify(input rail_t r);
        rail_view_t c;
        c.symbol = ($countones(r) == 1);
        c.clash  = ($countones(r) > 1);
        c.spacer = (r == 4'b0000);
        c.pair   = rail_to_pair(r);
        return c;
    endfunction

endpackage

// File: rtl/qlink_sync.sv
module qlink_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/qlink_tx.sv
module qlink_tx
    import quad_link_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    output rail_t             rail,
    input  logic              ack_in
);
    localparam int SYMS  = WORD_W / 2;
    localparam int CNT_W = (SYMS > 1) ? $clog2(SYMS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYMS - 1);

    tx_state_e         state;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              ack_s;

    qlink_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_in),
        .q   (ack_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            rail  <= '0;
            shreg <= '0;
            cnt   <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (s_valid) begin
                        shreg <= s_data;
                        rail  <= pair_to_rail(s_data[1:0]);
                        cnt   <= '0;
                        state <= TX_MARK;
                    end
                end
                TX_MARK: begin
                    if (ack_s) begin
                        rail  <= '0;
                        state <= TX_SPACE;
                    end
                end
                TX_SPACE: begin
                    if (!ack_s) begin
                        if (cnt == LAST) begin
                            state <= TX_IDLE;
                        end else begin
                            shreg <= {2'b00, shreg[WORD_W-1:2]};
                            rail  <= pair_to_rail(shreg[3:2]);
                            cnt   <= cnt + 1'b1;
                            state <= TX_MARK;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign s_ready = (state == TX_IDLE);
endmodule

// File: rtl/qlink_rx.sv
module qlink_rx
    import quad_link_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  rail_t             rail_in,
    output logic              ack,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [WORD_W-1:0] m_data,
    output logic              error
);
    localparam int SYMS  = WORD_W / 2;
    localparam int CNT_W = (SYMS > 1) ? $clog2(SYMS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYMS - 1);

    rx_state_e         state;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    rail_t             rail_s;
    rail_view_t        view;

    qlink_sync #(.W(4), .STAGES(SYNC_STAGES)) u_rail_sync (
        .clk (clk),
        .rst (rst),
        .d   (rail_in),
        .q   (rail_s)
    );

    assign view = classify(rail_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_MARK;
            shreg <= '0;
            cnt   <= '0;
            ack   <= 1'b0;
            error <= 1'b0;
        end else begin
            error <= view.clash;
            unique case (state)
                RX_MARK: begin
                    if (view.symbol) begin
                        shreg <= {view.pair, shreg[WORD_W-1:2]};
                        ack   <= 1'b1;
                        state <= RX_SPACE;
                    end
                end
                RX_SPACE: begin
                    if (view.spacer) begin
                        ack <= 1'b0;
                        if (cnt == LAST) begin
                            state <= RX_HOLD;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            state <= RX_MARK;
                        end
                    end
                end
                RX_HOLD: begin
                    if (m_ready) begin
                        cnt   <= '0;
                        state <= RX_MARK;
                    end
                end
                default: state <= RX_MARK;
            endcase
        end
    end

    assign m_valid = (state == RX_HOLD);
    assign m_data  = shreg;
endmodule

// File: rtl/quad_rail_link.sv
module quad_rail_link
    import quad_link_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    output logic [3:0]        tx_rail,
    input  logic              tx_ack_in,
    input  logic [3:0]        rx_rail_in,
    output logic              rx_ack,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [WORD_W-1:0] m_data,
    output logic              rx_error
);
    qlink_tx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .s_data  (s_data),
        .rail    (tx_rail),
        .ack_in  (tx_ack_in)
    );

    qlink_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rail_in (rx_rail_in),
        .ack     (rx_ack),
        .m_valid (m_valid),
        .m_ready (m_ready),
        .m_data  (m_data),
        .error   (rx_error)
    );
endmodule

// File: rtl/quad_rail_link_chk.sv
module quad_rail_link_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              s_valid,
    input logic              s_ready,
    input logic [3:0]        tx_rail,
    input logic              rx_ack,
    input logic              m_valid,
    input logic              m_ready,
    input logic [WORD_W-1:0] m_data,
    input logic              rx_error
);
    assert_tx_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_rail));

    assert_tx_hold_or_space_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_rail) != 4'b0000) |-> (tx_rail == $past(tx_rail) || tx_rail == 4'b0000));

    assert_ready_drops_R5: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> !s_ready);

    assert_valid_with_ack_low_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(m_valid) |-> !rx_ack);

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    assert_no_ack_on_clash_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ack) |-> !rx_error);
endmodule

bind quad_rail_link quad_rail_link_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .tx_rail  (tx_rail),
    .rx_ack   (rx_ack),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .rx_error (rx_error)
);

// File: tb/tb_quad_rail_link.sv
module tb_quad_rail_link;
    localparam int WORD_W = 32;
    localparam int SYMS   = WORD_W / 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [WORD_W-1:0] s_data = '0;
    logic [3:0]        tx_rail;
    logic              tx_ack_in;
    logic [3:0]        rx_rail_in;
    logic              rx_ack;
    logic              m_valid;
    logic              m_ready = 1'b0;
    logic [WORD_W-1:0] m_data;
    logic              rx_error;

    logic       loop_en   = 1'b0;
    logic [3:0] bench_rail = 4'b0000;
    logic       bench_ack  = 1'b0;

    assign rx_rail_in = loop_en ? tx_rail : bench_rail;
    assign tx_ack_in  = loop_en ? rx_ack  : bench_ack;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    quad_rail_link #(.WORD_W(WORD_W), .SYNC_STAGES(2)) dut (
        .clk        (clk),
        .rst        (rst),
        .s_valid    (s_valid),
        .s_ready    (s_ready),
        .s_data     (s_data),
        .tx_rail    (tx_rail),
        .tx_ack_in  (tx_ack_in),
        .rx_rail_in (rx_rail_in),
        .rx_ack     (rx_ack),
        .m_valid    (m_valid),
        .m_ready    (m_ready),
        .m_data     (m_data),
        .rx_error   (rx_error)
    );

    function automatic logic [3:0] exp_rail(input logic [WORD_W-1:0] w, input int k);
        logic [1:0] p;
        p = w[2*k +: 2];
        return 4'b0001 << p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send_word(input logic [WORD_W-1:0] w);
        int t = 0;
        while (!s_ready && t < 2000) begin tick(); t++; end
        s_valid = 1'b1;
        s_data  = w;
        tick();
        s_valid = 1'b0;
        chk(s_ready == 1'b0, "R5 ready low after accept", 32'(s_ready), 32'd0);
    endtask

    task automatic bench_symbol(input logic [3:0] r);
        int t = 0;
        bench_rail = r;
        while (!rx_ack && t < 50) begin tick(); t++; end
        chk(rx_ack == 1'b1, "R6 ack rises on symbol", 32'(rx_ack), 32'd1);
        bench_rail = 4'b0000;
        t = 0;
        while (rx_ack && t < 50) begin tick(); t++; end
        chk(rx_ack == 1'b0, "R6 ack falls on spacer", 32'(rx_ack), 32'd0);
    endtask

    task automatic loop_word(input logic [WORD_W-1:0] w, input int stall);
        int t = 0;
        send_word(w);
        while (!m_valid && t < 3000) begin tick(); t++; end
        chk(m_data == w, "R10 loopback word", m_data, w);
        m_ready = 1'b0;
        for (int i = 0; i < stall; i++) tick();
        chk(m_valid == 1'b1 && m_data == w, "R8 held during stall", m_data, w);
        m_ready = 1'b1;
        tick();
        m_ready = 1'b0;
        chk(m_valid == 1'b0, "R8 valid clears after take", 32'(m_valid), 32'd0);
    endtask

    initial begin
        logic [WORD_W-1:0] w;
        logic [WORD_W-1:0] w2;
        int t;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk(tx_rail == 4'b0000, "R1 tx_rail", 32'(tx_rail), 32'd0);
        chk(rx_ack == 1'b0, "R1 rx_ack", 32'(rx_ack), 32'd0);
        chk(s_ready == 1'b1, "R1 s_ready", 32'(s_ready), 32'd1);
        chk(m_valid == 1'b0, "R1 m_valid", 32'(m_valid), 32'd0);
        chk(rx_error == 1'b0, "R1 rx_error", 32'(rx_error), 32'd0);

        // Transmit end against a slow bench receiver: R2 R3 R4 R5
        for (int n = 0; n < 3; n++) begin
            w = (n == 0) ? 32'hE4E4_1B1B : $urandom();
            send_word(w);
            for (int k = 0; k < SYMS; k++) begin
                t = 0;
                while (tx_rail == 4'b0000 && t < 50) begin tick(); t++; end
                chk(tx_rail == exp_rail(w, k), "R2 R3 symbol value and order",
                    32'(tx_rail), 32'(exp_rail(w, k)));
                repeat (6) tick();
                chk(tx_rail == exp_rail(w, k), "R4 symbol held until ack",
                    32'(tx_rail), 32'(exp_rail(w, k)));
                bench_ack = 1'b1;
                t = 0;
                while (tx_rail != 4'b0000 && t < 50) begin tick(); t++; end
                repeat (6) tick();
                chk(tx_rail == 4'b0000, "R4 spacer held until ack low", 32'(tx_rail), 32'd0);
                chk(s_ready == 1'b0, "R5 ready low mid word", 32'(s_ready), 32'd0);
                bench_ack = 1'b0;
            end
            repeat (6) tick();
            chk(s_ready == 1'b1, "R5 ready back after last symbol", 32'(s_ready), 32'd1);
        end

        // Receive end driven by the bench: R9 then R6 R7 R8
        bench_rail = 4'b0101;
        repeat (8) tick();
        chk(rx_error == 1'b1, "R9 error on clash", 32'(rx_error), 32'd1);
        chk(rx_ack == 1'b0, "R9 no ack on clash", 32'(rx_ack), 32'd0);
        bench_rail = 4'b1111;
        repeat (8) tick();
        chk(rx_error == 1'b1 && rx_ack == 1'b0, "R9 all wires high", 32'(rx_ack), 32'd0);
        bench_rail = 4'b0000;
        repeat (8) tick();
        chk(rx_error == 1'b0, "R9 error clears on spacer", 32'(rx_error), 32'd0);

        w = 32'h8000_0003;
        for (int k = 0; k < SYMS; k++) begin
            bench_symbol(exp_rail(w, k));
            if (k < SYMS - 1) begin
                repeat (3) tick();
                chk(m_valid == 1'b0, "R7 no valid before last symbol", 32'(m_valid), 32'd0);
            end
        end
        t = 0;
        while (!m_valid && t < 20) begin tick(); t++; end
        chk(m_valid == 1'b1, "R7 valid after last spacer", 32'(m_valid), 32'd1);
        chk(m_data == w, "R7 rebuilt word, clash not counted", m_data, w);

        // R8 a new symbol is not acknowledged while the word is held
        w2 = $urandom();
        bench_rail = exp_rail(w2, 0);
        repeat (10) tick();
        chk(rx_ack == 1'b0, "R8 no ack while holding", 32'(rx_ack), 32'd0);
        chk(m_valid == 1'b1 && m_data == w, "R8 word stable", m_data, w);
        m_ready = 1'b1;
        tick();
        m_ready = 1'b0;
        t = 0;
        while (!rx_ack && t < 50) begin tick(); t++; end
        chk(rx_ack == 1'b1, "R8 ack after word taken", 32'(rx_ack), 32'd1);
        bench_rail = 4'b0000;
        t = 0;
        while (rx_ack && t < 50) begin tick(); t++; end
        for (int k = 1; k < SYMS; k++) bench_symbol(exp_rail(w2, k));
        t = 0;
        while (!m_valid && t < 20) begin tick(); t++; end
        chk(m_data == w2, "R7 second rebuilt word", m_data, w2);
        m_ready = 1'b1;
        tick();
        m_ready = 1'b0;

        // Loopback: R10 with directed and random words
        tick();
        loop_en = 1'b1;
        loop_word(32'h0000_0000, 0);
        loop_word(32'hFFFF_FFFF, 3);
        loop_word(32'hAAAA_AAAA, 0);
        loop_word(32'h5555_5555, 1);
        for (int n = 0; n < 20; n++) begin
            loop_word($urandom(), int'($urandom() % 5));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule